// File: doc/BRIEF.md
# Serial Configuration Port with Latch Bank and Status Readback

A host writes configuration words into this block over three wires: a serial clock, a serial data line and a load strobe. Each rising edge of the serial clock shifts one data bit into an internal word register, most significant bit first. On a rising edge of the strobe, the assembled word is copied into one of fourteen configuration latches. The four lowest bits of the word choose the latch. All latch contents are driven out in parallel to the logic they configure.

Latch code 7 also requests a readback. When the host writes to it, the block picks a latch using bits [7:4] of the written word and takes bits [19:4] of that latch as a 16-bit value. It then sends the value out on a separate serial output, highest bit first, and each serial clock rising edge moves to the next bit. The three serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and edge detectors follow.

Top module: `cfg_serial_port`

## Requirements
- R1: On each rising edge of the serial clock, the data-line level is shifted into bit 0 of the 32-bit word register and all other bits move up one place, so the first bit sent ends up at bit 31 after 32 edges.
- R2: After reset, latch k (k = 0..13) holds a 32-bit value built as follows: bits [3:0] equal k, bits [19:4] equal 16'h5A00 + 257*k, and all other bits are zero.
- R3: On a rising edge of the load strobe, the word register is copied into the latch whose number equals word bits [3:0]. No other latch changes.
- R4: A strobe while word bits [3:0] hold 14 or 15 changes no latch.
- R5: A strobe with word bits [3:0] = 7 requests a readback. The 16-bit value is bits [19:4] of the latch numbered by bits [7:4] of that same word, taken after the write. If that number is 14 or 15, the value is zero.
- R6: After a readback request, the serial output shows value bit 15. Each serial clock rising edge then moves it to the next lower bit. After the 16th such edge the output returns to low.
- R7: The serial output holds its level between serial clock rising edges. It is low after reset and whenever no readback is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from host |
| ser_dat_i | input | 1 | Serial data from host |
| ser_le_i | input | 1 | Load strobe from host |
| ser_rd_o | output | 1 | Serial readback data |
| cfg_o | output | 448 | All fourteen latches, latch k in bits [32k+31:32k] |

## Verification
A wrong latch decode appears on cfg_o within a few system cycles of the strobe edge: the wrong latch changes, or a neighbour is disturbed. An error in the shift register or the synchroniser shows up as a bit-rotated value in the target latch. A readback shifter that is out of step, or that stops at the wrong count, is caught on the first incorrect bit at ser_rd_o. It is also caught if the output is not low after the sixteenth edge.

// File: rtl/cfg_sp_pkg.sv
package cfg_sp_pkg;
  localparam int WORD_W  = 32;
  localparam int CTRL_W  = 4;
  localparam int NUM_LAT = 14;
  localparam int RB_W    = 16;
  localparam int RB_LSB  = 4;
  localparam int RB_ADDR = 7;
  localparam int SEL_LSB = 4;

  function automatic logic [WORD_W-1:0] dflt_word(input int k);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CTRL_W-1:0]    = CTRL_W'(k);
    w[RB_LSB +: RB_W] = RB_W'(16'h5A00 + k * 257);
    return w;
  endfunction
endpackage

// File: rtl/cfg_sp_sync.sv
module cfg_sp_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cfg_sp_shift.sv
module cfg_sp_shift #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (shift_i) word_q <= {word_q[W-2:0], din_i};
  end

  assign word_o = word_q;

  AST_SHIFT_IN_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (word_q[0] == $past(din_i)) && (word_q[W-1:1] == $past(word_q[W-2:0]))); // R1
endmodule

// File: rtl/cfg_sp_bank.sv
module cfg_sp_bank
  import cfg_sp_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int N     = NUM_LAT,
  parameter int CW    = CTRL_W,
  parameter int RW    = RB_W,
  parameter int RLSB  = RB_LSB
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [CW-1:0]  addr_i,
  input  logic [W-1:0]   word_i,
  input  logic [CW-1:0]  rd_sel_i,
  output logic [RW-1:0]  rd_val_o,
  output logic [N*W-1:0] cfg_o
);
  logic [W-1:0] lat_q [N];

  for (genvar k = 0; k < N; k++) begin : g_lat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            lat_q[k] <= dflt_word(k);
      else if (wr_i && addr_i == CW'(k))      lat_q[k] <= word_i;
    end
    assign cfg_o[k*W +: W] = lat_q[k];

    AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == CW'(k)) |=> lat_q[k] == $past(word_i)); // R3
    AST_LATCH_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && addr_i == CW'(k)) |=> $stable(lat_q[k])); // R3
  end

  always_comb begin
    rd_val_o = '0;
    for (int k = 0; k < N; k++)
      if (rd_sel_i == CW'(k)) rd_val_o = lat_q[k][RLSB +: RW];
  end

  AST_HIGH_CODE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && int'(addr_i) >= N) |=> $stable(cfg_o)); // R4
endmodule

// File: rtl/cfg_sp_readback.sv
module cfg_sp_readback #(
  parameter int RW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          adv_i,
  input  logic [RW-1:0] val_i,
  output logic          sdo_o
);
  localparam int CNT_W = $clog2(RW + 1);

  logic [RW-1:0]    sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (arm_i) begin
      sh_q  <= val_i;
      cnt_q <= CNT_W'(RW);
      act_q <= 1'b1;
    end else if (adv_i && act_q) begin
      sh_q  <= {sh_q[RW-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) act_q <= 1'b0;
    end
  end

  assign sdo_o = act_q & sh_q[RW-1];

  AST_RB_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> sdo_o == $past(val_i[RW-1])); // R6
  AST_RB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !adv_i) |=> $stable(sdo_o)); // R7
  AST_RB_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (cnt_q != '0) && (int'(cnt_q) <= RW)); // R6
  AST_RB_END_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && adv_i && act_q && cnt_q == CNT_W'(1)) |=> !sdo_o); // R6
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_sp_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int N    = NUM_LAT,
  parameter int CW   = CTRL_W,
  parameter int RW   = RB_W,
  parameter int RLSB = RB_LSB
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_le_i,
  output logic           ser_rd_o,
  output logic [N*W-1:0] cfg_o
);
  localparam logic [CW-1:0] RB_CODE = CW'(RB_ADDR);

  logic [2:0]    sync_q;
  logic          clk_p_q, le_p_q;
  logic          clk_rise, le_rise;
  logic [W-1:0]  word;
  logic          arm_q;
  logic [CW-1:0] sel_q;
  logic [RW-1:0] rd_val;

  cfg_sp_sync #(.W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ser_le_i, ser_clk_i, ser_dat_i}),
    .q_o    (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_p_q <= 1'b0;
      le_p_q  <= 1'b0;
    end else begin
      clk_p_q <= sync_q[1];
      le_p_q  <= sync_q[2];
    end
  end

  assign clk_rise = sync_q[1] & ~clk_p_q;
  assign le_rise  = sync_q[2] & ~le_p_q;

  cfg_sp_shift #(.W(W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (clk_rise),
    .din_i   (sync_q[0]),
    .word_o  (word)
  );

  cfg_sp_bank #(.W(W), .N(N), .CW(CW), .RW(RW), .RLSB(RLSB)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (le_rise),
    .addr_i   (word[CW-1:0]),
    .word_i   (word),
    .rd_sel_i (sel_q),
    .rd_val_o (rd_val),
    .cfg_o    (cfg_o)
  );

  // arm one cycle late so a readback of the setup latch sees the new word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      sel_q <= '0;
    end else begin
      arm_q <= le_rise && (word[CW-1:0] == RB_CODE);
      if (le_rise) sel_q <= word[SEL_LSB +: CW];
    end
  end

  cfg_sp_readback #(.RW(RW)) u_rb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm_q),
    .adv_i  (clk_rise),
    .val_i  (rd_val),
    .sdo_o  (ser_rd_o)
  );

  AST_ARM_ON_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && word[CW-1:0] == RB_CODE) |=> arm_q); // R5
  AST_IDLE_LOW_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !ser_rd_o); // R7
endmodule

// File: tb/cfg_serial_port_bench.sv
`timescale 1ns/1ps
module cfg_serial_port_bench;
  localparam int W = 32;
  localparam int N = 14;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
  logic rd;
  logic [N*W-1:0] cfg;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] model [N];
  logic [15:0] exp_q[$];
  logic [15:0] act_q[$];

  always #2.5 clk = ~clk;

  cfg_serial_port u_cfg_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .ser_le_i(sle), .ser_rd_o(rd), .cfg_o(cfg)
  );

  function automatic logic [W-1:0] reset_val(input int k);
    logic [15:0] p;
    p = 16'h5A00 + 16'(k * 257);
    return {12'h000, p, 4'(k)};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sclk_pulse(input logic b);
    sdat = b; sclk = 1'b0; wait_clk(HP);
    sclk = 1'b1; wait_clk(HP);
    sclk = 1'b0;
  endtask

  task automatic write_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) sclk_pulse(w[i]);
    wait_clk(HP);
    sle = 1'b1; wait_clk(HP);
    sle = 1'b0; wait_clk(2 * HP);
    if (w[3:0] < 4'd14) model[w[3:0]] = w;
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < N; k++)
      check(cfg[k*W +: W] === model[k], req, cfg[k*W +: W], model[k]);
  endtask

  // driver: request readback of latch sel, push expected value, collect bits
  task automatic readback(input logic [3:0] sel, input logic [11:0] tag);
    logic [15:0] got;
    logic [W-1:0] w;
    logic held;
    w = {12'h000, tag, sel, 4'd7};
    write_word(w);
    exp_q.push_back(sel < 4'd14 ? model[sel][19:4] : 16'h0000); // R5
    for (int i = 15; i >= 0; i--) begin
      got[i] = rd;
      held = rd;
      wait_clk(2);
      check(rd === held, "R7 hold", {31'b0, rd}, {31'b0, held});
      sclk_pulse(1'b0);
      wait_clk(HP);
    end
    act_q.push_back(got);
    check(rd === 1'b0, "R6 idle after 16 edges", {31'b0, rd}, '0);
  endtask

  // monitor
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        logic [15:0] a, e;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        check(a === e, "R6 readback order", {16'b0, a}, {16'b0, e});
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] snap;
    for (int k = 0; k < N; k++) model[k] = reset_val(k);
    wait_clk(5);
    check(rd === 1'b0, "R7 reset low", {31'b0, rd}, '0);
    rst_n = 1'b1;
    wait_clk(5);
    check_all("R2 reset default");
    check(rd === 1'b0, "R7 idle low", {31'b0, rd}, '0);

    // R2 defaults via readback
    readback(4'd0, 12'h000);
    readback(4'd13, 12'h000);
    readback(4'd5, 12'h000);

    // R1 R3: write every latch
    for (int k = 0; k < N; k++) begin
      logic [W-1:0] v;
      v = (32'h8137_9BD0 ^ (32'(k) * 32'h0F1E_2D30));
      v[3:0] = 4'(k);
      write_word(v);
      check_all("R3 latch write");
      check(cfg[k*W +: W] === v, "R1 shift order", cfg[k*W +: W], v);
    end

    // R4 ignored codes
    snap = cfg[0 +: W];
    write_word(32'hFFFF_FFFE);
    check_all("R4 code 14 ignored");
    write_word(32'h1234_567F);
    check_all("R4 code 15 ignored");
    check(cfg[0 +: W] === snap, "R4 latch 0 kept", cfg[0 +: W], snap);

    // R5 R6 readback after writes
    readback(4'd3, 12'hA5C);
    readback(4'd12, 12'h3C3);
    readback(4'd7, 12'h9E1);
    readback(4'd14, 12'hFFF);
    readback(4'd15, 12'h001);
    check_all("R3 after readbacks");
    check(rd === 1'b0, "R7 idle after readback", {31'b0, rd}, '0);

    wait (act_q.size() == 0);
    wait_clk(4);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule